// File: doc/BRIEF.md
# Software Interrupt Context-Save Sequencer

This block carries out the software-interrupt instruction of a small 8-bit accumulator processor. The decoder presents an opcode with a `start` strobe. When that opcode is the software-interrupt code and the sequencer is idle, the block captures the current program counter, accumulator, index byte, condition-code byte and stack pointer. It then runs a fixed multi-cycle program over a byte-wide memory port.

The program first forms the return address, which is the program counter plus one. It writes five context bytes to a stack that grows toward lower addresses. Each write goes to the current stack pointer, and the pointer drops by one after the write. Next the block sets the interrupt-mask bit in its copy of the condition codes. Finally it reads a two-byte service-routine address from a fixed vector location, high byte first.

A one-cycle `done` pulse marks the cycle in which the new stack pointer, program counter and condition codes are valid on the outputs. Those outputs then hold until the next launch. Fetching, decoding of other opcodes and the return path belong to the surrounding core.

Top module: `swi_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0.
- R2: A `start` with any opcode other than 0x83 leaves the block idle, with no memory write and no `done`.
- R3: A `start` with opcode 0x83 while idle launches the sequence, counting the launch edge's cycle as cycle 0. `done` is high for exactly one cycle, the 11th cycle after launch, and is low in the cycles before it.
- R4: The stacked bytes are stored as follows, where SP is the captured stack pointer and all arithmetic is modulo 2^16:
  - at address SP: the low byte of PC+1;
  - at SP-1: the high byte of PC+1;
  - at SP-2: the index byte;
  - at SP-3: the accumulator;
  - at SP-4: the condition-code byte as it was before masking.
- R5: Exactly one memory write occurs per cycle in cycles 2 to 6 after launch, in the order given in R4. `mem_we` is low at every other time.
- R6: When `done` is high, `sp_out` equals the captured SP minus 5, modulo 2^16.
- R7: When `done` is high, `ccr_out` equals the captured condition-code byte with bit 3 (the interrupt mask) forced to 1 and every other bit unchanged.
- R8: When `done` is high, `pc_out` equals the byte read at 0xFFFC (upper half) joined to the byte read at 0xFFFD (lower half).
- R9: `mem_addr` is 0xFFFC in cycle 8 and 0xFFFD in cycle 9 after launch, so the high vector byte is read before the low one.
- R10: A `start` that arrives while `busy` is high is ignored: the running sequence keeps its timing and data, and no second `done` follows.
- R11: A PC of 0xFFFF stacks a return address of 0x0000, and stacking wraps the stack pointer through 0x0000 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opcode-valid strobe from the decoder |
| opcode | input | 8 | Decoded opcode byte |
| pc_in | input | 16 | Program counter of the instruction |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | Index byte |
| ccr_in | input | 8 | Condition-code byte |
| sp_in | input | 16 | Stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, combinational for `mem_addr` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Service-routine address |
| ccr_out | output | 8 | Condition codes with the mask set |

## Verification
Each result is due at a fixed cycle counted from the launch edge:
- the five stack writes fall in cycles 2 to 6;
- the vector addresses appear in cycles 8 and 9;
- `done`, together with the final SP, PC and CCR, appears in cycle 11.

The bench drives inputs on falling edges and steps cycle by cycle, sampling on each falling edge. It checks `done` low in cycles 1 to 10 and high in cycle 11. It checks the address in cycles 8 and 9, and the outputs in cycle 11.

A driver task queues the expected write address and data for each launch. A monitor pops one entry for every write it sees and compares the two. Any write that arrives with the queue empty counts as a failure, which covers the ignored-opcode and busy-restart cases.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    SRC_PCL = 3'd0,
    SRC_PCH = 3'd1,
    SRC_X   = 3'd2,
    SRC_A   = 3'd3,
    SRC_CCR = 3'd4
  } push_src_e;

  function automatic logic [ADDR_W-1:0] ret_pc(input logic [ADDR_W-1:0] pc);
    return pc + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] sp_step(input logic [ADDR_W-1:0] sp);
    return sp - {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] mask_ccr(input logic [DATA_W-1:0] ccr,
                                                 input int unsigned bitpos);
    logic [DATA_W-1:0] r;
    r = ccr;
    r[bitpos] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/swi_step_ctr.sv
module swi_step_ctr #(
  parameter int unsigned STEPS = 11,
  localparam int unsigned CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  output logic [CW-1:0] step,
  output logic          busy,
  output logic          last
);
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
    end else if (step == '0) begin
      if (launch) step <= CW'(1);
    end else if (step == LAST_STEP) begin
      step <= '0;
    end else begin
      step <= step + CW'(1);
    end
  end

  assign busy = (step != '0);
  assign last = (step == LAST_STEP);
endmodule

// File: rtl/swi_push_mux.sv
module swi_push_mux
  import swi_pkg::*;
(
  input  push_src_e         sel,
  input  logic [ADDR_W-1:0] pc_ret,
  input  logic [DATA_W-1:0] x_val,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] ccr_val,
  output logic [DATA_W-1:0] wdata
);
  always_comb begin
    unique case (sel)
      SRC_PCL: wdata = pc_ret[DATA_W-1:0];
      SRC_PCH: wdata = pc_ret[ADDR_W-1:DATA_W];
      SRC_X:   wdata = x_val;
      SRC_A:   wdata = a_val;
      SRC_CCR: wdata = ccr_val;
      default: wdata = '0;
    endcase
  end
endmodule

// File: rtl/swi_ctx_regs.sv
module swi_ctx_regs
  import swi_pkg::*;
#(
  parameter int unsigned I_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              push_fire,
  input  logic              set_mask,
  input  logic              vec_hi_rd,
  input  logic              vec_lo_rd,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] pc_r,
  output logic [DATA_W-1:0] a_r,
  output logic [DATA_W-1:0] x_r,
  output logic [DATA_W-1:0] ccr_r,
  output logic [ADDR_W-1:0] sp_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_r  <= '0;
      a_r   <= '0;
      x_r   <= '0;
      ccr_r <= '0;
      sp_r  <= '0;
    end else if (capture) begin
      pc_r  <= ret_pc(pc_in);
      a_r   <= a_in;
      x_r   <= x_in;
      ccr_r <= ccr_in;
      sp_r  <= sp_in;
    end else begin
      if (push_fire) sp_r <= sp_step(sp_r);
      if (set_mask)  ccr_r <= mask_ccr(ccr_r, I_BIT);
      if (vec_hi_rd) pc_r[ADDR_W-1:DATA_W] <= rd_byte;
      if (vec_lo_rd) pc_r[DATA_W-1:0] <= rd_byte;
    end
  end
endmodule

// File: rtl/swi_seq.sv
module swi_seq
  import swi_pkg::*;
#(
  parameter logic [DATA_W-1:0] TRIG_OP     = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_HI_ADDR = 16'hFFFC,
  parameter int unsigned       I_BIT       = 3,
  parameter int unsigned       PUSH_FIRST  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [15:0]       pc_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        x_in,
  input  logic [7:0]        ccr_in,
  input  logic [15:0]       sp_in,
  output logic [15:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       sp_out,
  output logic [15:0]       pc_out,
  output logic [7:0]        ccr_out
);
  localparam int unsigned PUSH_CNT  = 5;
  localparam int unsigned PUSH_LAST = PUSH_FIRST + PUSH_CNT - 1;
  localparam int unsigned MASK_STEP = PUSH_LAST + 1;
  localparam int unsigned VHI_STEP  = MASK_STEP + 1;
  localparam int unsigned VLO_STEP  = VHI_STEP + 1;
  localparam int unsigned STEPS     = VLO_STEP + 2;
  localparam int unsigned CW        = $clog2(STEPS + 1);

  logic [CW-1:0]     step;
  logic              last;
  logic              launch;
  logic              push_fire;
  logic              set_mask;
  logic              vec_hi_rd;
  logic              vec_lo_rd;
  push_src_e         push_sel;
  logic [ADDR_W-1:0] pc_r;
  logic [DATA_W-1:0] a_r, x_r, ccr_r;
  logic [ADDR_W-1:0] sp_r;

  assign launch    = start && (opcode == TRIG_OP) && !busy;
  assign push_fire = (step >= CW'(PUSH_FIRST)) && (step <= CW'(PUSH_LAST));
  assign set_mask  = (step == CW'(MASK_STEP));
  assign vec_hi_rd = (step == CW'(VHI_STEP));
  assign vec_lo_rd = (step == CW'(VLO_STEP));
  assign push_sel  = push_src_e'(3'(step - CW'(PUSH_FIRST)));

  swi_step_ctr #(.STEPS(STEPS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .step(step), .busy(busy), .last(last)
  );

  swi_ctx_regs #(.I_BIT(I_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .capture(launch),
    .push_fire(push_fire), .set_mask(set_mask),
    .vec_hi_rd(vec_hi_rd), .vec_lo_rd(vec_lo_rd),
    .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .rd_byte(mem_rdata),
    .pc_r(pc_r), .a_r(a_r), .x_r(x_r), .ccr_r(ccr_r), .sp_r(sp_r)
  );

  swi_push_mux u_mux (
    .sel(push_sel), .pc_ret(pc_r), .x_val(x_r), .a_val(a_r),
    .ccr_val(ccr_r), .wdata(mem_wdata)
  );

  always_comb begin
    if (vec_hi_rd)      mem_addr = VEC_HI_ADDR;
    else if (vec_lo_rd) mem_addr = VEC_HI_ADDR + 16'd1;
    else                mem_addr = sp_r;
  end

  assign mem_we  = push_fire;
  assign done    = last;
  assign sp_out  = sp_r;
  assign pc_out  = pc_r;
  assign ccr_out = ccr_r;
endmodule

// File: rtl/swi_seq_chk.sv
module swi_seq_chk #(
  parameter int unsigned STEPS = 11,
  parameter int unsigned I_BIT = 3,
  parameter logic [15:0] VEC_HI_ADDR = 16'hFFFC
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  opcode,
  input logic        launch,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        vec_hi_rd,
  input logic        vec_lo_rd,
  input logic [15:0] sp_out,
  input logic [7:0]  ccr_out
);
  logic [7:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (launch)     cyc <= 8'd1;
    else if (cyc != '0)  cyc <= (cyc == 8'(STEPS)) ? 8'd0 : cyc + 8'd1;
  end

  // R3
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == 8'(STEPS)));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  we_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R6
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !launch) |=> (sp_out == $past(sp_out) - 16'd1));
  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ccr_out[I_BIT]);
  // R9
  vec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_lo_rd |-> ($past(vec_hi_rd) && mem_addr == VEC_HI_ADDR + 16'd1));
  // R2
  other_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode != 8'h83 && !busy) |=> !busy);
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind swi_seq swi_seq_chk #(
  .STEPS(STEPS), .I_BIT(I_BIT), .VEC_HI_ADDR(VEC_HI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .launch(launch),
  .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
  .vec_hi_rd(vec_hi_rd), .vec_lo_rd(vec_lo_rd), .sp_out(sp_out),
  .ccr_out(ccr_out)
);

// File: tb/swi_seq_tb.sv
module swi_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, ccr_in = '0;
  logic [15:0] mem_addr, sp_out, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, ccr_out;
  logic        mem_we, busy, done;
  logic [7:0]  vec_hi = 8'h12, vec_lo = 8'h34;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [15:0] addr; logic [7:0] data; } wr_t;
  wr_t wq[$];
  logic [7:0] stack_seen [int];

  always #2.5 clk = ~clk;

  assign mem_rdata = (mem_addr == 16'hFFFC) ? vec_hi :
                     (mem_addr == 16'hFFFD) ? vec_lo : 8'hEE;

  swi_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .sp_out(sp_out), .pc_out(pc_out), .ccr_out(ccr_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every write must match the head of the queue (R4, R5, R2, R10)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R5 unexpected write", {mem_addr, 8'h00, mem_wdata}, 32'h0);
      end else begin
        wr_t e;
        e = wq.pop_front();
        chk(mem_addr == e.addr && mem_wdata == e.data, "R4 stacked byte",
            {mem_addr, 8'h00, mem_wdata}, {e.addr, 8'h00, e.data});
        stack_seen[int'(mem_addr)] = mem_wdata;
      end
    end
  end

  task automatic run_swi(input logic [15:0] pc, input logic [7:0] a,
                         input logic [7:0] x, input logic [7:0] ccr,
                         input logic [15:0] sp, input bit poke_busy);
    logic [15:0] rp;
    rp = pc + 16'd1;
    wq.push_back('{sp, rp[7:0]});
    wq.push_back('{sp - 16'd1, rp[15:8]});
    wq.push_back('{sp - 16'd2, x});
    wq.push_back('{sp - 16'd3, a});
    wq.push_back('{sp - 16'd4, ccr});
    @(negedge clk);
    start = 1'b1; opcode = 8'h83;
    pc_in = pc; a_in = a; x_in = x; ccr_in = ccr; sp_in = sp;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke_busy && k == 3) begin
        start = 1'b1; pc_in = 16'h5555; sp_in = 16'h0100; a_in = 8'h77;
      end
      chk(done == (k == 11), (k == 11) ? "R3 done in cycle 11" : "R3 done early",
          {31'd0, done}, {31'd0, (k == 11)});
      if (k == 8) chk(mem_addr == 16'hFFFC, "R9 vector high addr", mem_addr, 16'hFFFC);
      if (k == 9) chk(mem_addr == 16'hFFFD, "R9 vector low addr", mem_addr, 16'hFFFD);
      if (k == 11) begin
        chk(sp_out == sp - 16'd5, "R6 final sp", sp_out, sp - 16'd5);
        chk(ccr_out == (ccr | 8'h08), "R7 ccr mask", ccr_out, ccr | 8'h08);
        chk(pc_out == {vec_hi, vec_lo}, "R8 vector pc", pc_out, {vec_hi, vec_lo});
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R3 single pulse", {31'd0, done}, 32'd0);
    chk(wq.size() == 0, "R5 five writes", wq.size(), 0);
    for (int j = 0; j < 5; j++) begin
      logic [15:0] ad;
      logic [7:0]  ex;
      ad = sp - 16'(j);
      ex = (j == 0) ? rp[7:0] : (j == 1) ? rp[15:8] : (j == 2) ? x : (j == 3) ? a : ccr;
      chk(stack_seen.exists(int'(ad)) && stack_seen[int'(ad)] == ex,
          "R4 stack image", stack_seen.exists(int'(ad)) ? stack_seen[int'(ad)] : 8'hXX, ex);
    end
    stack_seen.delete();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_we, "R1 reset outputs", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_we, "R1 idle after reset", {busy, done, mem_we}, 0);

    run_swi(16'h1234, 8'hA5, 8'h3C, 8'hC1, 16'h00FF, 1'b0);
    vec_hi = 8'hF0; vec_lo = 8'h0D;
    run_swi(16'h8000, 8'h00, 8'hFF, 8'h08, 16'h4000, 1'b0);

    // R2 other opcode ignored
    @(negedge clk);
    start = 1'b1; opcode = 8'h84; sp_in = 16'h2222;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 14; k++) begin
      chk(!done && !busy, "R2 other opcode idle", {busy, done}, 0);
      @(negedge clk);
    end
    chk(sp_out == 16'h3FFB, "R2 state untouched", sp_out, 16'h3FFB);

    // R10 start during busy ignored
    vec_hi = 8'hAB; vec_lo = 8'hCD;
    run_swi(16'h0420, 8'h11, 8'h22, 8'h00, 16'h0300, 1'b1);
    repeat (12) @(negedge clk);
    chk(!done && !busy, "R10 no second run", {busy, done}, 0);

    // R11 wrap of PC and SP
    run_swi(16'hFFFF, 8'h5A, 8'h6B, 8'hF7, 16'h0002, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule